// File: doc/BRIEF.md
# ATA Task File Register Front End

This block is the host-facing register set of a flash storage card that speaks the ATA command protocol over a PC Card style bus. The host presents a register offset on four address lines, two active-low byte-lane chip selects, active-low read and write strobes and a 16-bit data bus. The block works out which registers the cycle touches and on which byte lane each one travels. It holds the command parameters, the status image, device control and a pending-interrupt flag. It drives read data, an active-low interrupt request and an active-low 16-bit-cycle indication back to the host.

On the other side, a narrow port lets a backend sequencer load status, error and data, and raise an interrupt. The block hands that sequencer each command opcode as a one-cycle pulse, together with the parameter registers. Every clock edge at which a strobe is low counts as one host access, so the host holds a strobe low for exactly one cycle per access.

Top module: `ata_taskfile_if`

## Requirements
- R1: The chip selects pick the cycle type. ce1_n low with ce2_n high is a byte cycle: register `addr` moves on bits 7:0. Both low is a word cycle: register `{addr[3:1],0}` moves on bits 7:0 and register `{addr[3:1],1}` on bits 15:8, except that pair 0 carries the data high byte on bits 15:8. ce1_n high with ce2_n low is an odd-byte cycle: register `{addr[3:1],1}` moves on bits 15:8. Unused read lanes return 0.
- R2: The offsets are 0 data, 1 error (read) / feature (write), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status (read) / command (write), 13 (0xD) a duplicate of offset 1, and 14 (0xE) alternate status (read) / device control (write).
- R3: The data register is 16 bits wide. Offsets 0 and 8 reach its low byte, and offset 9 reaches its high byte. A word cycle at pair 0 or pair 8 moves the whole word.
- R4: Drive/head bit 4 is the drive select and bits 3:0 are the head number. Offset 15 (0xF) reads bits 7:6 = 11, bits 5:2 = the inverted head number, bit 1 = drive select and bit 0 = the inverted drive select.
- R5: A read that reaches offset 7 clears the pending interrupt. A read of offset 0xE returns the same status byte and leaves the pending interrupt unchanged.
- R6: Device control bit 1 masks the interrupt. While it is set, ireq_n stays high, but the pending flag is kept, so clearing the bit raises the request again.
- R7: A write to offset 7 sets status bit 7 (busy). On the next cycle it drives cmd_valid high for exactly one cycle, with the opcode on cmd_code.
- R8: After reset the interface is in 16-bit mode. A command 0xEF written while the feature register holds 0x01 selects byte mode. The same command with feature 0x81 restores 16-bit mode.
- R9: iois16_n is low when a byte or word cycle decodes offset 0 or 8 while in 16-bit mode. Otherwise it is high.
- R10: A backend pulse on be_irq sets the pending flag. When that pulse and a clearing status read fall in the same cycle, the pulse wins. The be_status_we, be_error_we and be_data_we strobes load the status, error and data registers.
- R11: Reset leaves status at 0x50, all other registers at 0, ireq_n high and cmd_valid low.
- R12: With both chip selects high, writes change no register and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| ce1_n | input | 1 | Low-lane chip select, active low |
| ce2_n | input | 1 | High-lane chip select, active low |
| iord_n | input | 1 | Read strobe, active low |
| iowr_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| iois16_n | output | 1 | Low when the cycle targets a 16-bit register |
| ireq_n | output | 1 | Interrupt request, active low |
| be_status_we | input | 1 | Backend status load |
| be_status | input | 8 | Backend status value |
| be_error_we | input | 1 | Backend error load |
| be_error | input | 8 | Backend error value |
| be_data_we | input | 1 | Backend data load |
| be_data | input | 16 | Backend data value |
| be_irq | input | 1 | Backend interrupt pulse |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 8 | Last command opcode |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count |
| tf_sector | output | 8 | Sector number |
| tf_cyl | output | 16 | Cylinder high and low |
| tf_drv | output | 1 | Drive select |
| tf_head | output | 4 | Head number |
| tf_data | output | 16 | Data register |

## Verification
The hardest states to reach are those where interrupt masking and status reads interleave. In these states the pending flag must survive a mask, must survive a read of the alternate status register and must then be cleared only by a read of the primary status register. The stimulus raises a backend interrupt, reads the alternate status register and then the primary one, and checks ireq_n after each access. It then sets the mask, raises the interrupt again, removes the mask, and clears the flag through a word read of the pair that holds status. The byte-mode switch is reached by writing the feature register through both of its offsets, issuing the mode command, and probing iois16_n at the data offsets.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_BYTE = 2'd1,
        CYC_WORD = 2'd2,
        CYC_ODD  = 2'd3
    } cyc_e;

    typedef struct packed {
        cyc_e       cyc;
        logic       lo_en;
        logic       hi_en;
        logic [3:0] lo_off;
        logic [3:0] hi_off;
    } lane_sel_t;

    localparam logic [3:0] OFF_DATA = 4'h0;
    localparam logic [3:0] OFF_ERR  = 4'h1;
    localparam logic [3:0] OFF_CNT  = 4'h2;
    localparam logic [3:0] OFF_SEC  = 4'h3;
    localparam logic [3:0] OFF_CYLL = 4'h4;
    localparam logic [3:0] OFF_CYLH = 4'h5;
    localparam logic [3:0] OFF_DH   = 4'h6;
    localparam logic [3:0] OFF_STAT = 4'h7;
    localparam logic [3:0] OFF_DEVN = 4'h8;
    localparam logic [3:0] OFF_DODD = 4'h9;
    localparam logic [3:0] OFF_ERRD = 4'hD;
    localparam logic [3:0] OFF_CTRL = 4'hE;
    localparam logic [3:0] OFF_DADR = 4'hF;

    localparam logic [7:0] OPC_SETFEAT = 8'hEF;
    localparam logic [7:0] FEAT_BYTE   = 8'h01;
    localparam logic [7:0] FEAT_WORD   = 8'h81;
    localparam logic [7:0] STATUS_RST  = 8'h50;
    localparam int         BSY_BIT     = 7;
    localparam int         NIEN_BIT    = 1;

    function automatic logic [7:0] drive_addr(input logic drv, input logic [3:0] head);
        return {2'b11, ~head, drv, ~drv};
    endfunction

endpackage

// File: rtl/ata_lane_decode.sv
`timescale 1ns/1ps
module ata_lane_decode
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    output lane_sel_t         sel
);
    localparam int PAIR_W = ADDR_W - 1;

    logic [ADDR_W-1:0] pair_even;
    logic [ADDR_W-1:0] pair_odd;

    assign pair_even = {addr[ADDR_W-1:1], 1'b0};
    assign pair_odd  = {addr[ADDR_W-1:1], 1'b1};

    always_comb begin
        sel = '0;
        unique case ({ce1_n, ce2_n})
            2'b01: begin
                sel.cyc    = CYC_BYTE;
                sel.lo_en  = 1'b1;
                sel.lo_off = addr;
            end
            2'b00: begin
                sel.cyc    = CYC_WORD;
                sel.lo_en  = 1'b1;
                sel.hi_en  = 1'b1;
                sel.lo_off = pair_even;
                sel.hi_off = (addr[ADDR_W-1:1] == PAIR_W'(0)) ? OFF_DODD : pair_odd;
            end
            2'b10: begin
                sel.cyc    = CYC_ODD;
                sel.hi_en  = 1'b1;
                sel.hi_off = pair_odd;
            end
            default: sel = '0;
        endcase
    end

endmodule

// File: rtl/ata_irq_ctl.sv
`timescale 1ns/1ps
module ata_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic nien,
    output logic ireq_n
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)       pend_q <= 1'b0;
        else if (set)  pend_q <= 1'b1;
        else if (clr)  pend_q <= 1'b0;
    end

    assign ireq_n = ~(pend_q & ~nien);

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> pend_q);

    // R5
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend_q);

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(pend_q));

    // R6
    mask_chk: assert property (@(posedge clk) disable iff (rst)
        nien |-> ireq_n);

endmodule

// File: rtl/ata_tf_regs.sv
`timescale 1ns/1ps
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_sel_t         sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              be_status_we,
    input  logic [7:0]        be_status,
    input  logic              be_error_we,
    input  logic [7:0]        be_error,
    input  logic              be_data_we,
    input  logic [DATA_W-1:0] be_data,
    output logic [DATA_W-1:0] rdata,
    output logic              stat_rd,
    output logic              nien,
    output logic              byte_mode,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic [7:0]        tf_feature,
    output logic [7:0]        tf_count,
    output logic [7:0]        tf_sector,
    output logic [15:0]       tf_cyl,
    output logic              tf_drv,
    output logic [3:0]        tf_head,
    output logic [DATA_W-1:0] tf_data
);
    localparam int N_OFF = 1 << ADDR_W;

    logic [N_OFF-1:0] wen;
    logic [7:0]       wbyte [N_OFF];

    for (genvar o = 0; o < N_OFF; o++) begin : g_wen
        logic lo_hit, hi_hit;
        assign lo_hit   = wr_stb && sel.lo_en && (sel.lo_off == ADDR_W'(o));
        assign hi_hit   = wr_stb && sel.hi_en && (sel.hi_off == ADDR_W'(o));
        assign wen[o]   = lo_hit | hi_hit;
        assign wbyte[o] = hi_hit ? wdata[15:8] : wdata[7:0];
    end

    logic [DATA_W-1:0] data_q;
    logic [7:0] err_q, feat_q, cnt_q, sec_q, cyll_q, cylh_q, dh_q, stat_q, devctl_q;
    logic       byte_mode_q, cmd_valid_q;
    logic [7:0] cmd_code_q;
    logic       cmd_wr;

    assign cmd_wr = wen[OFF_STAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            err_q       <= '0;
            feat_q      <= '0;
            cnt_q       <= '0;
            sec_q       <= '0;
            cyll_q      <= '0;
            cylh_q      <= '0;
            dh_q        <= '0;
            stat_q      <= STATUS_RST;
            devctl_q    <= '0;
            byte_mode_q <= 1'b0;
            cmd_valid_q <= 1'b0;
            cmd_code_q  <= '0;
        end else begin
            if (be_data_we)   data_q <= be_data;
            if (be_error_we)  err_q  <= be_error;
            if (be_status_we) stat_q <= be_status;
            if (wen[OFF_DATA])      data_q[7:0]  <= wbyte[OFF_DATA];
            else if (wen[OFF_DEVN]) data_q[7:0]  <= wbyte[OFF_DEVN];
            if (wen[OFF_DODD])      data_q[15:8] <= wbyte[OFF_DODD];
            if (wen[OFF_ERR])       feat_q <= wbyte[OFF_ERR];
            else if (wen[OFF_ERRD]) feat_q <= wbyte[OFF_ERRD];
            if (wen[OFF_CNT])  cnt_q    <= wbyte[OFF_CNT];
            if (wen[OFF_SEC])  sec_q    <= wbyte[OFF_SEC];
            if (wen[OFF_CYLL]) cyll_q   <= wbyte[OFF_CYLL];
            if (wen[OFF_CYLH]) cylh_q   <= wbyte[OFF_CYLH];
            if (wen[OFF_DH])   dh_q     <= wbyte[OFF_DH];
            if (wen[OFF_CTRL]) devctl_q <= wbyte[OFF_CTRL];
            cmd_valid_q <= cmd_wr;
            if (cmd_wr) begin
                cmd_code_q      <= wbyte[OFF_STAT];
                stat_q[BSY_BIT] <= 1'b1;
                if (wbyte[OFF_STAT] == OPC_SETFEAT) begin
                    if (feat_q == FEAT_BYTE)      byte_mode_q <= 1'b1;
                    else if (feat_q == FEAT_WORD) byte_mode_q <= 1'b0;
                end
            end
        end
    end

    function automatic logic [7:0] rd_byte(input logic [ADDR_W-1:0] off);
        case (off)
            OFF_DATA, OFF_DEVN: return data_q[7:0];
            OFF_DODD:           return data_q[15:8];
            OFF_ERR, OFF_ERRD:  return err_q;
            OFF_CNT:            return cnt_q;
            OFF_SEC:            return sec_q;
            OFF_CYLL:           return cyll_q;
            OFF_CYLH:           return cylh_q;
            OFF_DH:             return dh_q;
            OFF_STAT, OFF_CTRL: return stat_q;
            OFF_DADR:           return drive_addr(dh_q[4], dh_q[3:0]);
            default:            return 8'h00;
        endcase
    endfunction

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (sel.lo_en) rdata[7:0]  = rd_byte(sel.lo_off);
            if (sel.hi_en) rdata[15:8] = rd_byte(sel.hi_off);
        end
    end

    assign stat_rd    = rd_stb && ((sel.lo_en && sel.lo_off == OFF_STAT) ||
                                   (sel.hi_en && sel.hi_off == OFF_STAT));
    assign nien       = devctl_q[NIEN_BIT];
    assign byte_mode  = byte_mode_q;
    assign cmd_valid  = cmd_valid_q;
    assign cmd_code   = cmd_code_q;
    assign tf_feature = feat_q;
    assign tf_count   = cnt_q;
    assign tf_sector  = sec_q;
    assign tf_cyl     = {cylh_q, cyll_q};
    assign tf_drv     = dh_q[4];
    assign tf_head    = dh_q[3:0];
    assign tf_data    = data_q;

    // R7
    cmd_bsy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (cmd_valid && stat_q[BSY_BIT]));

    // R7
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> !cmd_valid);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(byte_mode_q));

endmodule

// File: rtl/ata_taskfile_if.sv
`timescale 1ns/1ps
module ata_taskfile_if
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              iois16_n,
    output logic              ireq_n,
    input  logic              be_status_we,
    input  logic [7:0]        be_status,
    input  logic              be_error_we,
    input  logic [7:0]        be_error,
    input  logic              be_data_we,
    input  logic [DATA_W-1:0] be_data,
    input  logic              be_irq,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic [7:0]        tf_feature,
    output logic [7:0]        tf_count,
    output logic [7:0]        tf_sector,
    output logic [15:0]       tf_cyl,
    output logic              tf_drv,
    output logic [3:0]        tf_head,
    output logic [DATA_W-1:0] tf_data
);
    lane_sel_t sel;
    logic      stat_rd, nien, byte_mode;

    ata_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .ce1_n (ce1_n),
        .ce2_n (ce2_n),
        .sel   (sel)
    );

    ata_tf_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .sel          (sel),
        .rd_stb       (~iord_n),
        .wr_stb       (~iowr_n),
        .wdata        (wdata),
        .be_status_we (be_status_we),
        .be_status    (be_status),
        .be_error_we  (be_error_we),
        .be_error     (be_error),
        .be_data_we   (be_data_we),
        .be_data      (be_data),
        .rdata        (rdata),
        .stat_rd      (stat_rd),
        .nien         (nien),
        .byte_mode    (byte_mode),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .tf_feature   (tf_feature),
        .tf_count     (tf_count),
        .tf_sector    (tf_sector),
        .tf_cyl       (tf_cyl),
        .tf_drv       (tf_drv),
        .tf_head      (tf_head),
        .tf_data      (tf_data)
    );

    ata_irq_ctl u_irq (
        .clk    (clk),
        .rst    (rst),
        .set    (be_irq),
        .clr    (stat_rd),
        .nien   (nien),
        .ireq_n (ireq_n)
    );

    assign iois16_n = ~(~byte_mode && sel.lo_en &&
                        (sel.lo_off == OFF_DATA || sel.lo_off == OFF_DEVN));

    // R12
    idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && ce2_n) |-> (rdata == '0));

    // R9
    odd_io16_chk: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && !ce2_n) |-> iois16_n);

endmodule

// File: tb/ata_taskfile_if_tb_top.sv
`timescale 1ns/1ps
module ata_taskfile_if_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        iois16_n, ireq_n;
    logic        be_status_we = 1'b0, be_error_we = 1'b0, be_data_we = 1'b0, be_irq = 1'b0;
    logic [7:0]  be_status = '0, be_error = '0;
    logic [15:0] be_data = '0;
    logic        cmd_valid;
    logic [7:0]  cmd_code, tf_feature, tf_count, tf_sector;
    logic [15:0] tf_cyl, tf_data;
    logic        tf_drv;
    logic [3:0]  tf_head;

    always #4 clk = ~clk;

    ata_taskfile_if dut_i (
        .clk(clk), .rst(rst), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .wdata(wdata), .rdata(rdata),
        .iois16_n(iois16_n), .ireq_n(ireq_n),
        .be_status_we(be_status_we), .be_status(be_status),
        .be_error_we(be_error_we), .be_error(be_error),
        .be_data_we(be_data_we), .be_data(be_data), .be_irq(be_irq),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .tf_feature(tf_feature),
        .tf_count(tf_count), .tf_sector(tf_sector), .tf_cyl(tf_cyl),
        .tf_drv(tf_drv), .tf_head(tf_head), .tf_data(tf_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per host read cycle
    always @(negedge clk) begin
        if (!iord_n) begin
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, {16'h0, rdata}, {16'h0, e.v});
            end
        end
    end

    task automatic host_rd(input logic [3:0] a, input logic c1, input logic c2,
                           input logic [15:0] exp, input string tag);
        exp_t e;
        @(posedge clk); #1;
        addr = a; ce1_n = c1; ce2_n = c2; iord_n = 1'b0;
        e.v = exp; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        iord_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    task automatic host_wr(input logic [3:0] a, input logic c1, input logic c2,
                           input logic [15:0] d);
        @(posedge clk); #1;
        addr = a; ce1_n = c1; ce2_n = c2; iowr_n = 1'b0; wdata = d;
        @(posedge clk); #1;
        iowr_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    task automatic probe_io16(input logic [3:0] a, input logic c1, input logic c2,
                              input logic exp, input string tag);
        @(posedge clk); #1;
        addr = a; ce1_n = c1; ce2_n = c2;
        #2;
        chk(tag, {31'h0, iois16_n}, {31'h0, exp});
        ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    task automatic be_pulse_irq();
        @(posedge clk); #1; be_irq = 1'b1;
        @(posedge clk); #1; be_irq = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        chk("R11 ireq_n after reset", {31'h0, ireq_n}, 32'd1);
        chk("R11 cmd_valid after reset", {31'h0, cmd_valid}, 32'd0);
        chk("R11 count after reset", {24'h0, tf_count}, 32'h0);
        host_rd(4'h7, 1'b0, 1'b1, 16'h0050, "R11 status reset value");
        probe_io16(4'h0, 1'b0, 1'b0, 1'b0, "R8 16-bit mode after reset");

        // R2 parameter registers, R1 lanes
        host_wr(4'h2, 1'b0, 1'b1, 16'h0001);
        host_wr(4'h3, 1'b0, 1'b1, 16'h0022);
        host_wr(4'h4, 1'b0, 1'b0, 16'h1234);
        host_wr(4'h6, 1'b0, 1'b1, 16'h00B5);
        chk("R2 cylinder via word write", {16'h0, tf_cyl}, 32'h1234);
        chk("R4 drive select", {31'h0, tf_drv}, 32'd1);
        chk("R4 head number", {28'h0, tf_head}, 32'h5);
        host_rd(4'h2, 1'b0, 1'b0, 16'h2201, "R1 word read count/sector");
        host_rd(4'h4, 1'b1, 1'b0, 16'h1200, "R1 odd-byte read upper lane");
        host_rd(4'h5, 1'b0, 1'b1, 16'h0012, "R2 cylinder high byte read");
        host_rd(4'hF, 1'b0, 1'b1, 16'h00EA, "R4 drive address byte");

        // R3 data register
        host_wr(4'h0, 1'b0, 1'b0, 16'hBEEF);
        chk("R3 data word write", {16'h0, tf_data}, 32'hBEEF);
        host_rd(4'h8, 1'b0, 1'b1, 16'h00EF, "R3 even data port");
        host_rd(4'h9, 1'b0, 1'b1, 16'h00BE, "R3 odd data port");
        host_rd(4'h8, 1'b0, 1'b0, 16'hBEEF, "R3 word read pair 8");
        host_rd(4'h8, 1'b1, 1'b0, 16'hBE00, "R1 odd-byte data high");
        host_wr(4'h9, 1'b0, 1'b1, 16'h0077);
        host_wr(4'h0, 1'b0, 1'b1, 16'h0011);
        chk("R3 byte writes to data", {16'h0, tf_data}, 32'h7711);

        // R10 backend loads
        @(posedge clk); #1; be_data_we = 1'b1; be_data = 16'h1357;
        be_error_we = 1'b1; be_error = 8'h04;
        @(posedge clk); #1; be_data_we = 1'b0; be_error_we = 1'b0;
        host_rd(4'h0, 1'b0, 1'b0, 16'h1357, "R10 backend data load");
        host_rd(4'h1, 1'b0, 1'b1, 16'h0004, "R10 backend error load");
        host_rd(4'hD, 1'b0, 1'b1, 16'h0004, "R2 duplicate error offset");

        // R9 16-bit indication
        probe_io16(4'h8, 1'b0, 1'b1, 1'b0, "R9 iois16 at offset 8");
        probe_io16(4'h2, 1'b0, 1'b0, 1'b1, "R9 iois16 at offset 2");
        probe_io16(4'h9, 1'b0, 1'b1, 1'b1, "R9 iois16 at offset 9");
        probe_io16(4'h0, 1'b1, 1'b1, 1'b1, "R9 iois16 in standby");

        // R7 command
        host_wr(4'h7, 1'b0, 1'b1, 16'h0020);
        chk("R7 cmd_valid pulse", {31'h0, cmd_valid}, 32'd1);
        chk("R7 cmd_code", {24'h0, cmd_code}, 32'h20);
        @(posedge clk); #1;
        chk("R7 cmd_valid one cycle", {31'h0, cmd_valid}, 32'd0);
        host_rd(4'hE, 1'b0, 1'b1, 16'h00D0, "R7 busy set after command");

        // R8 set features
        host_wr(4'h1, 1'b0, 1'b1, 16'h0001);
        chk("R2 feature write", {24'h0, tf_feature}, 32'h01);
        host_wr(4'h7, 1'b0, 1'b1, 16'h00EF);
        probe_io16(4'h0, 1'b0, 1'b0, 1'b1, "R8 byte mode selected");
        host_wr(4'hD, 1'b0, 1'b1, 16'h0081);
        chk("R2 feature via duplicate offset", {24'h0, tf_feature}, 32'h81);
        host_wr(4'h7, 1'b0, 1'b1, 16'h00EF);
        probe_io16(4'h0, 1'b0, 1'b0, 1'b0, "R8 16-bit mode restored");

        // R5 interrupt clear rules
        @(posedge clk); #1; be_status_we = 1'b1; be_status = 8'h50;
        @(posedge clk); #1; be_status_we = 1'b0;
        be_pulse_irq();
        chk("R10 irq raised", {31'h0, ireq_n}, 32'd0);
        host_rd(4'hE, 1'b0, 1'b1, 16'h0050, "R5 alternate status value");
        chk("R5 alt read keeps irq", {31'h0, ireq_n}, 32'd0);
        host_rd(4'h7, 1'b0, 1'b1, 16'h0050, "R5 status value");
        chk("R5 status read clears irq", {31'h0, ireq_n}, 32'd1);

        // R6 mask
        host_wr(4'hE, 1'b0, 1'b1, 16'h0002);
        be_pulse_irq();
        chk("R6 masked irq", {31'h0, ireq_n}, 32'd1);
        host_wr(4'hE, 1'b0, 1'b1, 16'h0000);
        chk("R6 pending kept under mask", {31'h0, ireq_n}, 32'd0);
        host_rd(4'h6, 1'b0, 1'b0, 16'h50B5, "R1 word read status/drive-head");
        chk("R5 word status read clears irq", {31'h0, ireq_n}, 32'd1);

        // R1 odd-byte write
        host_wr(4'h2, 1'b1, 1'b0, 16'h6600);
        chk("R1 odd-byte write sector", {24'h0, tf_sector}, 32'h66);
        host_rd(4'h3, 1'b0, 1'b1, 16'h0066, "R1 sector readback");

        // R12 standby
        host_wr(4'h2, 1'b1, 1'b1, 16'h00FF);
        host_rd(4'h2, 1'b0, 1'b1, 16'h0001, "R12 standby write ignored");
        host_rd(4'h7, 1'b1, 1'b1, 16'h0000, "R12 standby read zero");

        repeat (2) @(posedge clk);
        chk("scoreboard drained", sb_q.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule